// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block decides which of several interrupt sources the CPU should serve. Each request line is gated by its own bit in a mask register, and a fixed priority encoder then picks the winner among the requests that are pending and enabled. Sources with lower indices are meant for fast devices and always win over sources with higher indices.

When any enabled request is present, a status flag is set. The interrupt line to the CPU is that flag gated by a global enable input. When the CPU acknowledges, the block captures the winning source number as a two-bit vector and clears the flag. The vector then stays put until the next acknowledge that finds a request. Software nests interrupts by rewriting the mask. It can open only the sources above the one being served, or shut the sources below it. The mask is read and written through a small select/strobe register port.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After a synchronous reset the mask is all zeros (every source blocked), and the status flag, the CPU request, the vector and the read data are all 0.
- R2: A mask write (reg_sel=1, reg_wr=1) loads reg_wdata at the clock edge. Mask bit i = 1 enables source i. A read with reg_sel=1 presents the mask on reg_rdata after that edge. When reg_sel=0, reg_rdata is 0 after the edge.
- R3: A request whose mask bit is 0 never sets the status flag.
- R4: If any request is pending with its mask bit 1 and int_ack is low, the status flag is 1 after the next clock edge, and it stays 1 until an acknowledge.
- R5: Priority is fixed: among the unmasked pending requests, the lowest index wins. Its index (0..3) is the value captured into vec_addr.
- R6: When int_ack is high at a clock edge, the status flag is 0 after that edge. vec_addr takes the winning index if a request was pending at that edge and otherwise keeps its value. It changes at no other time.
- R7: cpu_irq after an edge equals the status flag after that edge ANDed with int_en as sampled at that edge.
- R8: A strobe with reg_sel=0 and reg_wr=1 leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 4 | Level-sensitive interrupt requests, index 0 highest |
| int_en | input | 1 | Global interrupt enable |
| int_ack | input | 1 | Interrupt acknowledge from CPU |
| reg_sel | input | 1 | Selects the mask register |
| reg_wr | input | 1 | Write strobe for the mask register |
| reg_wdata | input | 4 | Mask write data |
| reg_rdata | output | 4 | Registered mask read data |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 2 | Vector of the acknowledged source |
| ist | output | 1 | Interrupt status flag |

## Verification
The hardest case to reach is an acknowledge in the same cycle that several unmasked requests are pending and the mask is being rewritten. This cycle decides both the priority winner and whether the old mask still applies. Directed sequences build it deliberately: all sources raised, the mask narrowed step by step, and each level acknowledged in turn. Long random runs then toggle requests, mask writes and acknowledges at a high rate, so that these same-cycle collisions and acknowledges with nothing pending occur often.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned DEF_SRC = 4;

  function automatic int unsigned vec_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
  parameter int unsigned N_SRC = intr_pkg::DEF_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] rdata
);
  logic [N_SRC-1:0] mask_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= sel ? mask_q : '0;
      if (sel && wr) mask_q <= wdata;
    end
  end

  assign mask  = mask_q;
  assign rdata = rdata_q;

  // R8: no write strobe with select means the mask holds
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr) |=> $stable(mask_q));
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int unsigned N_SRC = intr_pkg::DEF_SRC,
  localparam int unsigned VW   = intr_pkg::vec_width(N_SRC)
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] mask,
  output logic             any,
  output logic [VW-1:0]    code
);
  logic [N_SRC-1:0] pend, win;

  assign pend = req & mask;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_win
    if (gi == 0) begin : g_top
      assign win[gi] = pend[gi];
    end else begin : g_rest
      assign win[gi] = pend[gi] & ~(|pend[gi-1:0]);
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (win[i]) code = code | VW'(i);
    end
  end

  assign any = |pend;

  // R5: a single winner, and it is a pending source
  always_comb begin
    if (any) begin
      p_one_winner_r5: assert ($onehot0(win) && win != '0);
    end
  end
endmodule

// File: rtl/intr_status.sv
module intr_status #(
  parameter int unsigned VW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any,
  input  logic [VW-1:0] code,
  input  logic          ack,
  input  logic          en,
  output logic          ist,
  output logic          irq,
  output logic [VW-1:0] vec
);
  logic          ist_q, irq_q, ist_d;
  logic [VW-1:0] vec_q;

  always_comb begin
    if (ack) ist_d = 1'b0;
    else     ist_d = ist_q | any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ist_q <= 1'b0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ist_q <= ist_d;
      irq_q <= ist_d & en;
      if (ack && any) vec_q <= code;
    end
  end

  assign ist = ist_q;
  assign irq = irq_q;
  assign vec = vec_q;

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ist_q);
  p_pending_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (any && !ack) |=> ist_q);
  p_vec_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !(ack && any) |=> $stable(vec_q));
  p_irq_needs_ist_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ist_q);
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned VW   = intr_pkg::vec_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             int_en,
  input  logic             int_ack,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             cpu_irq,
  output logic [VW-1:0]    vec_addr,
  output logic             ist
);
  logic [N_SRC-1:0] mask;
  logic             any;
  logic [VW-1:0]    code;

  intr_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr),
    .wdata(reg_wdata), .mask(mask), .rdata(reg_rdata)
  );

  intr_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req(irq_req), .mask(mask), .any(any), .code(code)
  );

  intr_status #(.VW(VW)) u_stat (
    .clk(clk), .rst(rst), .any(any), .code(code), .ack(int_ack),
    .en(int_en), .ist(ist), .irq(cpu_irq), .vec(vec_addr)
  );

  // R3: a status flag rising must come from an enabled request
  p_masked_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (!ist && ((irq_req & mask) == '0)) |=> !ist);
endmodule

// File: tb/sim_intr_prio_ctrl.sv
module sim_intr_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] irq_req = '0;
  logic       int_en = 1'b0, int_ack = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       cpu_irq, ist;
  logic [1:0] vec_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  logic [3:0] m_mask = '0, m_rdata = '0;
  logic       m_ist = 0, m_irq = 0;
  logic [1:0] m_vec = '0;

  always #10 clk = ~clk;

  intr_prio_ctrl u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .int_en(int_en),
    .int_ack(int_ack), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq),
    .vec_addr(vec_addr), .ist(ist)
  );

  function automatic logic [1:0] first_set(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, ist, m_ist, "ist");
    chk(tag, cpu_irq, m_irq, "cpu_irq");
    chk(tag, vec_addr, m_vec, "vec_addr");
    chk(tag, reg_rdata, m_rdata, "reg_rdata");
  endtask

  task automatic cyc(input string tag);
    logic [3:0] pend;
    logic       nxt;
    @(posedge clk);
    pend = irq_req & m_mask;
    m_rdata = reg_sel ? m_mask : 4'd0;
    if (reg_sel && reg_wr) m_mask = reg_wdata;
    nxt = int_ack ? 1'b0 : (m_ist | (|pend));
    if (int_ack && |pend) m_vec = first_set(pend);
    m_irq = nxt & int_en;
    m_ist = nxt;
    #5;
    check_all(tag);
  endtask

  task automatic idle();
    int_ack = 0; reg_sel = 0; reg_wr = 0;
  endtask

  task automatic wr_mask(input logic [3:0] v);
    reg_sel = 1; reg_wr = 1; reg_wdata = v;
    cyc("R2");
    idle();
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5 rst = 0;
    // R1 reset state
    chk("R1", ist, 0, "ist"); chk("R1", cpu_irq, 0, "cpu_irq");
    chk("R1", vec_addr, 0, "vec_addr"); chk("R1", reg_rdata, 0, "reg_rdata");
    reg_sel = 1; cyc("R1"); chk("R1", reg_rdata, 0, "mask after reset");
    idle();
    // R3 masked requests ignored
    irq_req = 4'hF; int_en = 1;
    repeat (3) cyc("R3");
    chk("R3", ist, 0, "ist masked");
    // R8 write without select ignored
    reg_sel = 0; reg_wr = 1; reg_wdata = 4'hF; cyc("R8"); idle();
    reg_sel = 1; cyc("R8"); chk("R8", reg_rdata, 0, "mask kept"); idle();
    // R2 write and read back
    wr_mask(4'b1010);
    reg_sel = 1; cyc("R2"); chk("R2", reg_rdata, 4'b1010, "readback"); idle();
    // R4 set, R5 priority with sources 1 and 3 open
    cyc("R4"); chk("R4", ist, 1, "ist set");
    chk("R7", cpu_irq, 1, "irq with enable");
    int_ack = 1; cyc("R6"); idle();
    chk("R5", vec_addr, 1, "vec winner 1"); chk("R6", ist, 0, "ist cleared");
    // nesting: open everything, source 0 wins
    wr_mask(4'hF);
    int_ack = 1; cyc("R5"); idle(); chk("R5", vec_addr, 0, "vec winner 0");
    // block higher ones, only 3 remains
    wr_mask(4'b1000);
    int_ack = 1; cyc("R5"); idle(); chk("R5", vec_addr, 3, "vec winner 3");
    // R6 ack with nothing pending keeps vector
    irq_req = 0; cyc("R6");
    int_ack = 1; cyc("R6"); idle(); chk("R6", vec_addr, 3, "vec held");
    // R7 enable low
    int_en = 0; irq_req = 4'b1000; cyc("R7");
    chk("R7", cpu_irq, 0, "irq disabled"); chk("R4", ist, 1, "ist held");
    cyc("R4"); chk("R4", ist, 1, "ist still held");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      irq_req   = 4'($urandom);
      int_en    = ($urandom % 4) != 0;
      int_ack   = ($urandom % 3) == 0;
      reg_sel   = ($urandom % 3) == 0;
      reg_wr    = ($urandom % 2) == 0;
      reg_wdata = 4'($urandom);
      cyc("R5");
    end
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule